// File: doc/BRIEF.md
# Serial Configuration Target Sequencer

This block is the control side of a device that receives its configuration image as a serial bit stream from an external host. A host asks for a new load by pulling an active-low request line low for long enough. The block then empties its user side, holds its open-drain status and done lines low, and waits for the request to return high. It then captures one data bit on every rising edge of the incoming configuration clock. When the image length has been reached it lets go of the done line, and it also hands the chain enable to the next device. Once the wired done line reads high, it runs a fixed initialisation count and announces user mode.

Open-drain lines are modelled as a drive-low enable going out and a sensed level coming back. The surrounding board, or the bench, forms the wired level from the block's enable, from external pull-downs and from an implied pull-up. If the external status line is pulled low during loading or initialisation, the block enters a locked fault state. It does the same on a mode strap other than passive serial or on an image error flag. In user mode, two global inputs act on the user pins: an output-enable that can float them all and a clear that can zero them all. The asynchronous inputs from the host side pass through a configurable synchroniser.

Top module: `cfgseq_target`

## Requirements
- R1: After rst_n, and in the reset state, stat_drv_lo=1, done_drv_lo=1, chain_en_n=1, init_done=0, user_oe=0 (all user pins floating) and user_q=0.
- R2: A low pulse on cfg_req_n shorter than MIN_CYC = ceil(2 us × CLK_HZ) clock cycles (100 at 50 MHz) is ignored in every state. A low level held for at least MIN_CYC cycles forces the reset state from any state.
- R3: When cfg_req_n is high in the reset state, the block starts a new load: stat_drv_lo goes to 0, done_drv_lo stays 1 and image_tail is cleared to 0.
- R4: During a load with chip_en_n low, each rising ser_clk edge captures ser_data. image_tail holds the most recent TAIL_W bits, with the newest bit in bit 0 and older bits shifted toward the MSB.
- R5: While chip_en_n is high, ser_clk edges are neither captured nor counted.
- R6: After exactly IMG_BITS captured bits, done_drv_lo goes to 0 and chain_en_n goes to 0. Before that bit count, both stay at 1.
- R7: Initialisation starts only when done_in reads high. While an external agent holds done_in low, init_done stays 0.
- R8: init_done rises exactly INIT_CYC+1 clock cycles after done_in first reads high (INIT_CYC=299 ticks plus one sensing cycle), using the system clock when use_uclk=0. With use_uclk=1, each synchronised rising uclk edge is one tick.
- R9: img_err high during a load enters the fault state: stat_drv_lo=1 and done_drv_lo=1. The block stays there until a valid reset request arrives, and further serial edges do not release it.
- R10: done_in or no, stat_in read low during loading, the done wait or initialisation enters the fault state, so init_done never rises.
- R11: During a load, mode_sel must be 2'b10 (passive serial). The codes 2'b00 (active serial), 2'b01 (fast active serial) and 2'b11 enter the fault state.
- R12: In user mode, user_oe is all ones while gout_en_n=1 and all zeros while gout_en_n=0. Outside user mode it is all zeros.
- R13: In user mode, user_q takes user_d one clock after it is presented. While gclr_n=0 it is zero from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req_n | input | 1 | Active-low configuration request (asynchronous) |
| chip_en_n | input | 1 | Active-low chip enable; high holds off loading |
| mode_sel | input | 2 | Mode strap; 2'b10 is passive serial |
| ser_clk | input | 1 | External configuration clock (asynchronous) |
| ser_data | input | 1 | Serial configuration data |
| img_err | input | 1 | Image error flag from outside |
| use_uclk | input | 1 | 1 selects uclk as the initialisation clock |
| uclk | input | 1 | User-supplied initialisation clock (asynchronous) |
| stat_in | input | 1 | Sensed level of the wired status line |
| done_in | input | 1 | Sensed level of the wired done line |
| gout_en_n | input | 1 | Global output enable, active low floats user pins |
| gclr_n | input | 1 | Global clear of user registers, active low |
| user_d | input | USER_W | User register data input |
| stat_drv_lo | output | 1 | Pulls the status line low when 1 |
| done_drv_lo | output | 1 | Pulls the done line low when 1 |
| chain_en_n | output | 1 | Chain enable to the next device, low once the image is in |
| init_done | output | 1 | High in user mode |
| image_tail | output | TAIL_W | Most recently captured bits |
| user_oe | output | USER_W | Per-pin drive enable (0 = high impedance) |
| user_q | output | USER_W | User register outputs |

## Verification
The global output-enable and the global clear both act on the user side, and they can be taken low in the same clock cycle. The bench lowers both together in user mode. It checks that every drive enable drops at once and that the registers read zero one clock later. It then releases only the output-enable while new data waits at user_d, and checks that the pins drive again but still show zero, which proves the clear is held apart from the enable. Last, it releases the clear and checks that the waiting data appears after one clock.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   typedef enum logic [2:0] {
      ST_RESET  = 3'd0,
      ST_LOAD   = 3'd1,
      ST_SETTLE = 3'd2,
      ST_INIT   = 3'd3,
      ST_USER   = 3'd4,
      ST_FAULT  = 3'd5
   } seq_state_t;

   localparam logic [1:0] MODE_PASSIVE = 2'b10;

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfgseq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/cfgseq_req_filter.sv
module cfgseq_req_filter #(
   parameter int unsigned MIN_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n_s,
   output logic fire
);

   localparam int LW = $clog2(MIN_CYC + 1);

   if (MIN_CYC < 1) begin : g_bad_min
      $error("cfgseq_req_filter: MIN_CYC must be at least 1");
   end

   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_cnt <= '0;
      else if (req_n_s)                 low_cnt <= '0;
      else if (low_cnt != LW'(MIN_CYC)) low_cnt <= low_cnt + 1'b1;
   end

   assign fire = !req_n_s && (low_cnt == LW'(MIN_CYC - 1));

endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
   import cfgseq_pkg::*;
#(
   parameter int unsigned IMG_BITS = 64,
   parameter int unsigned INIT_CYC = 299,
   parameter int          TAIL_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic              req_n_s,
   input  logic              chip_en_n,
   input  logic [1:0]        mode_sel,
   input  logic              ser_rise,
   input  logic              ser_bit,
   input  logic              img_err,
   input  logic              stat_in,
   input  logic              done_in,
   input  logic              init_tick,
   output seq_state_t        state,
   output logic [TAIL_W-1:0] tail
);

   localparam int BW = $clog2(IMG_BITS + 1);
   localparam int IW = $clog2(INIT_CYC + 1);

   logic [BW-1:0] bit_cnt;
   logic [IW-1:0] init_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_RESET;
         bit_cnt  <= '0;
         init_cnt <= '0;
         tail     <= '0;
      end else if (req_fire) begin
         state <= ST_RESET;
      end else begin
         unique case (state)
            ST_RESET: begin
               bit_cnt  <= '0;
               init_cnt <= '0;
               tail     <= '0;
               if (req_n_s) state <= ST_LOAD;
            end
            ST_LOAD: begin
               if (mode_sel != MODE_PASSIVE || img_err || !stat_in) begin
                  state <= ST_FAULT;
               end else if (!chip_en_n && ser_rise) begin
                  tail    <= TAIL_W'({tail, ser_bit});
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == BW'(IMG_BITS - 1)) state <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (!stat_in)     state <= ST_FAULT;
               else if (done_in) state <= ST_INIT;
            end
            ST_INIT: begin
               if (!stat_in) begin
                  state <= ST_FAULT;
               end else if (init_tick) begin
                  if (init_cnt == IW'(INIT_CYC - 1)) state <= ST_USER;
                  else                               init_cnt <= init_cnt + 1'b1;
               end
            end
            ST_USER:  state <= ST_USER;
            default:  state <= ST_FAULT;
         endcase
      end
   end

endmodule

// File: rtl/cfgseq_target.sv
module cfgseq_target
   import cfgseq_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned REQ_MIN_NS  = 2000,
   parameter int unsigned IMG_BITS    = 64,
   parameter int unsigned INIT_CYC    = 299,
   parameter int          TAIL_W      = 8,
   parameter int          USER_W      = 8,
   parameter int          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req_n,
   input  logic              chip_en_n,
   input  logic [1:0]        mode_sel,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              img_err,
   input  logic              use_uclk,
   input  logic              uclk,
   input  logic              stat_in,
   input  logic              done_in,
   input  logic              gout_en_n,
   input  logic              gclr_n,
   input  logic [USER_W-1:0] user_d,
   output logic              stat_drv_lo,
   output logic              done_drv_lo,
   output logic              chain_en_n,
   output logic              init_done,
   output logic [TAIL_W-1:0] image_tail,
   output logic [USER_W-1:0] user_oe,
   output logic [USER_W-1:0] user_q
);

   localparam longint unsigned REQ_PROD = longint'(CLK_HZ) * longint'(REQ_MIN_NS);
   localparam int unsigned     MIN_CYC  =
      int'((REQ_PROD + 64'd999_999_999) / 64'd1_000_000_000);

   if (IMG_BITS < 1) begin : g_bad_img
      $error("cfgseq_target: IMG_BITS must be at least 1");
   end
   if (INIT_CYC < 1) begin : g_bad_init
      $error("cfgseq_target: INIT_CYC must be at least 1");
   end
   if (TAIL_W < 1 || USER_W < 1) begin : g_bad_width
      $error("cfgseq_target: TAIL_W and USER_W must be at least 1");
   end

   // synchronised copies: {uclk, ser_data, ser_clk, cfg_req_n}
   logic [3:0] raw_in, syn_in;
   logic [1:0] edge_prev;
   logic       ser_rise, uclk_rise, init_tick, req_fire, in_user;
   seq_state_t state;

   assign raw_in = {uclk, ser_data, ser_clk, cfg_req_n};

   cfgseq_sync #(
      .WIDTH   (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b0001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_prev <= '0;
      else        edge_prev <= {syn_in[3], syn_in[1]};
   end

   assign ser_rise  = syn_in[1] & ~edge_prev[0];
   assign uclk_rise = syn_in[3] & ~edge_prev[1];
   assign init_tick = use_uclk ? uclk_rise : 1'b1;

   cfgseq_req_filter #(.MIN_CYC(MIN_CYC)) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_n_s (syn_in[0]),
      .fire    (req_fire)
   );

   cfgseq_ctrl #(
      .IMG_BITS (IMG_BITS),
      .INIT_CYC (INIT_CYC),
      .TAIL_W   (TAIL_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_fire),
      .req_n_s   (syn_in[0]),
      .chip_en_n (chip_en_n),
      .mode_sel  (mode_sel),
      .ser_rise  (ser_rise),
      .ser_bit   (syn_in[2]),
      .img_err   (img_err),
      .stat_in   (stat_in),
      .done_in   (done_in),
      .init_tick (init_tick),
      .state     (state),
      .tail      (image_tail)
   );

   assign in_user     = (state == ST_USER);
   assign stat_drv_lo = (state == ST_RESET) || (state == ST_FAULT);
   assign done_drv_lo = (state == ST_RESET) || (state == ST_LOAD) || (state == ST_FAULT);
   assign chain_en_n  = !((state == ST_SETTLE) || (state == ST_INIT) || in_user);
   assign init_done   = in_user;

   for (genvar i = 0; i < USER_W; i++) begin : g_io
      logic q_bit;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 q_bit <= 1'b0;
         else if (!in_user || !gclr_n) q_bit <= 1'b0;
         else                        q_bit <= user_d[i];
      end
      assign user_q[i]  = q_bit;
      assign user_oe[i] = in_user & gout_en_n;
   end

endmodule

// File: rtl/cfgseq_target_chk.sv
module cfgseq_target_chk #(
   parameter int USER_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stat_drv_lo,
   input logic              done_drv_lo,
   input logic              chain_en_n,
   input logic              init_done,
   input logic              done_in,
   input logic              gout_en_n,
   input logic              gclr_n,
   input logic [USER_W-1:0] user_oe,
   input logic [USER_W-1:0] user_q
);

   AST_STAT_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stat_drv_lo |-> (done_drv_lo && chain_en_n && !init_done && user_oe == '0)); // R1

   AST_CHAIN_AFTER_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
      !chain_en_n |-> !done_drv_lo); // R6

   AST_USER_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> ($past(done_in) && !done_drv_lo && !chain_en_n)); // R7

   AST_OE_ONLY_USER: assert property (@(posedge clk) disable iff (!rst_n)
      (user_oe != '0) |-> init_done); // R12

   AST_OE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !gout_en_n |-> (user_oe == '0)); // R12

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done && !gclr_n) |=> (user_q == '0)); // R13

endmodule

bind cfgseq_target cfgseq_target_chk #(.USER_W(USER_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stat_drv_lo (stat_drv_lo),
   .done_drv_lo (done_drv_lo),
   .chain_en_n  (chain_en_n),
   .init_done   (init_done),
   .done_in     (done_in),
   .gout_en_n   (gout_en_n),
   .gclr_n      (gclr_n),
   .user_oe     (user_oe),
   .user_q      (user_q)
);

// File: tb/cfgseq_target_test.sv
module cfgseq_target_test;

   localparam int IMG_BITS = 64;
   localparam int INIT_CYC = 299;
   localparam int TAIL_W   = 8;
   localparam int USER_W   = 8;
   localparam int MIN_LOW  = 100; // 2 us at 50 MHz

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_req_n = 1'b1;
   logic              chip_en_n = 1'b0;
   logic [1:0]        mode_sel = 2'b10;
   logic              ser_clk = 1'b0;
   logic              ser_data = 1'b0;
   logic              img_err = 1'b0;
   logic              use_uclk = 1'b0;
   logic              uclk = 1'b0;
   logic              ext_stat_lo = 1'b0;
   logic              ext_done_lo = 1'b0;
   logic              gout_en_n = 1'b1;
   logic              gclr_n = 1'b1;
   logic [USER_W-1:0] user_d = '0;
   logic              stat_in, done_in;
   logic              stat_drv_lo, done_drv_lo, chain_en_n, init_done;
   logic [TAIL_W-1:0] image_tail;
   logic [USER_W-1:0] user_oe, user_q;

   int          n_chk = 0;
   int          n_bad = 0;
   logic [TAIL_W-1:0] exp_tail;
   int          bit_idx = 0;

   always #10 clk = ~clk;

   // wired-AND of block drive and external pull-downs, with pull-up
   assign stat_in = ~(stat_drv_lo | ext_stat_lo);
   assign done_in = ~(done_drv_lo | ext_done_lo);

   cfgseq_target #(
      .IMG_BITS (IMG_BITS),
      .INIT_CYC (INIT_CYC),
      .TAIL_W   (TAIL_W),
      .USER_W   (USER_W)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_req_n   (cfg_req_n),
      .chip_en_n   (chip_en_n),
      .mode_sel    (mode_sel),
      .ser_clk     (ser_clk),
      .ser_data    (ser_data),
      .img_err     (img_err),
      .use_uclk    (use_uclk),
      .uclk        (uclk),
      .stat_in     (stat_in),
      .done_in     (done_in),
      .gout_en_n   (gout_en_n),
      .gclr_n      (gclr_n),
      .user_d      (user_d),
      .stat_drv_lo (stat_drv_lo),
      .done_drv_lo (done_drv_lo),
      .chain_en_n  (chain_en_n),
      .init_done   (init_done),
      .image_tail  (image_tail),
      .user_oe     (user_oe),
      .user_q      (user_q)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic pat_bit(input int i);
      return logic'(((i * 3) >> 1) & 1) ^ logic'(i % 5 == 0);
   endfunction

   // one serial bit; capture lands well inside the 14-cycle slot
   task automatic send_bit(input logic b, input bit counted);
      ser_data = b;
      cycles(4);
      ser_clk = 1'b1;
      cycles(5);
      ser_clk = 1'b0;
      cycles(5);
      if (counted) exp_tail = TAIL_W'({exp_tail, b});
   endtask

   task automatic send_pattern(input int n);
      for (int k = 0; k < n; k++) begin
         send_bit(pat_bit(bit_idx), 1'b1);
         bit_idx++;
      end
   endtask

   task automatic reset_request();
      cfg_req_n = 1'b0;
      cycles(MIN_LOW + 10);
      cfg_req_n = 1'b1;
      cycles(6);
      exp_tail = '0;
      bit_idx  = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      cycles(3);
      check(stat_drv_lo == 1'b1, "R1 stat_drv_lo", stat_drv_lo, 1);
      check(done_drv_lo == 1'b1, "R1 done_drv_lo", done_drv_lo, 1);
      check(chain_en_n == 1'b1 && init_done == 1'b0, "R1 chain/init", {chain_en_n, init_done}, 2'b10);
      check(user_oe == '0 && user_q == '0, "R1 user side", {user_oe, user_q}, 0);
      rst_n = 1'b1;
      cycles(4);
      check(stat_drv_lo == 1'b0 && done_drv_lo == 1'b1, "R3 load start", {stat_drv_lo, done_drv_lo}, 2'b01);
      check(image_tail == '0, "R3 tail cleared", image_tail, 0);
      exp_tail = '0;
      bit_idx  = 0;
   endtask

   task automatic t_full_load();
      int n;
      chip_en_n = 1'b1;
      for (int k = 0; k < 8; k++) send_bit(1'b1, 1'b0);
      check(image_tail == '0, "R5 no capture with chip disabled", image_tail, 0);
      check(done_drv_lo == 1'b1, "R5 done still low", done_drv_lo, 1);
      chip_en_n = 1'b0;
      send_pattern(IMG_BITS - 1);
      check(image_tail == exp_tail, "R4 tail contents", image_tail, exp_tail);
      check(done_drv_lo == 1'b1 && chain_en_n == 1'b1, "R6 before last bit", {done_drv_lo, chain_en_n}, 2'b11);
      ext_done_lo = 1'b1;
      send_pattern(1);
      check(done_drv_lo == 1'b0 && chain_en_n == 1'b0, "R6 image complete", {done_drv_lo, chain_en_n}, 2'b00);
      check(image_tail == exp_tail, "R4 tail after last bit", image_tail, exp_tail);
      cycles(400);
      check(init_done == 1'b0, "R7 held by external done pull", init_done, 0);
      ext_done_lo = 1'b0;
      n = 0;
      while (!init_done && n < 1000) begin
         @(negedge clk);
         n++;
      end
      check(n == INIT_CYC + 1, "R8 init duration", n, INIT_CYC + 1);
   endtask

   task automatic t_user();
      check(user_oe == '1, "R12 pins driven", user_oe, 8'hFF);
      user_d = 8'h5A;
      cycles(1);
      check(user_q == 8'h5A, "R13 register follows", user_q, 8'h5A);
      gout_en_n = 1'b0;
      gclr_n    = 1'b0;
      cycles(1);
      check(user_oe == '0, "R12 pins floated", user_oe, 0);
      check(user_q == '0, "R13 cleared", user_q, 0);
      gout_en_n = 1'b1;
      user_d    = 8'hC3;
      cycles(2);
      check(user_oe == '1 && user_q == '0, "R13 clear held apart from enable", {user_oe, user_q}, 16'hFF00);
      gclr_n = 1'b1;
      cycles(1);
      check(user_q == 8'hC3, "R13 data after clear", user_q, 8'hC3);
   endtask

   task automatic t_requests();
      cfg_req_n = 1'b0;
      cycles(MIN_LOW - 20);
      cfg_req_n = 1'b1;
      cycles(10);
      check(init_done == 1'b1 && stat_drv_lo == 1'b0, "R2 short pulse ignored", {init_done, stat_drv_lo}, 2'b10);
      cfg_req_n = 1'b0;
      cycles(MIN_LOW + 10);
      check(stat_drv_lo == 1'b1 && done_drv_lo == 1'b1, "R2 long pulse resets", {stat_drv_lo, done_drv_lo}, 2'b11);
      check(init_done == 1'b0 && chain_en_n == 1'b1 && user_oe == '0, "R1 reset state",
            {init_done, chain_en_n, user_oe}, 10'h100);
      cfg_req_n = 1'b1;
      cycles(6);
      check(stat_drv_lo == 1'b0 && image_tail == '0, "R3 new pass", {stat_drv_lo, image_tail}, 0);
      exp_tail = '0;
      bit_idx  = 0;
   endtask

   task automatic t_img_err();
      send_pattern(3);
      img_err = 1'b1;
      cycles(1);
      img_err = 1'b0;
      cycles(1);
      check(stat_drv_lo == 1'b1 && done_drv_lo == 1'b1, "R9 fault entry", {stat_drv_lo, done_drv_lo}, 2'b11);
      for (int k = 0; k < IMG_BITS; k++) send_bit(1'b1, 1'b0);
      check(stat_drv_lo == 1'b1 && chain_en_n == 1'b1, "R9 fault held", {stat_drv_lo, chain_en_n}, 2'b11);
      reset_request();
      check(stat_drv_lo == 1'b0, "R9 left by reset request", stat_drv_lo, 0);
   endtask

   task automatic t_ext_stat_load();
      send_pattern(2);
      ext_stat_lo = 1'b1;
      cycles(2);
      ext_stat_lo = 1'b0;
      cycles(1);
      check(stat_drv_lo == 1'b1, "R10 external status pull in load", stat_drv_lo, 1);
      reset_request();
   endtask

   task automatic t_mode();
      mode_sel = 2'b00;
      cycles(2);
      check(stat_drv_lo == 1'b1, "R11 active serial code faults", stat_drv_lo, 1);
      mode_sel = 2'b10;
      reset_request();
      mode_sel = 2'b01;
      cycles(2);
      check(stat_drv_lo == 1'b1, "R11 fast active code faults", stat_drv_lo, 1);
      mode_sel = 2'b10;
      reset_request();
      check(stat_drv_lo == 1'b0, "R11 passive code loads", stat_drv_lo, 0);
   endtask

   task automatic t_ext_stat_init();
      send_pattern(IMG_BITS);
      cycles(50);
      check(chain_en_n == 1'b0 && init_done == 1'b0, "R10 in initialisation", {chain_en_n, init_done}, 0);
      ext_stat_lo = 1'b1;
      cycles(2);
      ext_stat_lo = 1'b0;
      cycles(1);
      check(stat_drv_lo == 1'b1, "R10 external status pull in init", stat_drv_lo, 1);
      cycles(400);
      check(init_done == 1'b0, "R10 user mode never reached", init_done, 0);
   endtask

   initial begin
      exp_tail = '0;
      t_reset();
      t_full_load();
      t_user();
      t_requests();
      t_img_err();
      t_ext_stat_load();
      t_mode();
      t_ext_stat_init();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule